// File: doc/BRIEF.md
# Word-Bounded Header Group Reader

This block sits at the read side of a multi-read FIFO that holds packet headers. Each cycle it looks at the FIFO's output lanes in lane order and decides how many headers to pull out. The headers it takes are registered and passed to the next pipeline stage as one group, with a valid bit per lane. The number taken goes back to the FIFO as a read count in the same cycle.

A group is limited by the bytes it covers. The reader adds the header lengths one lane at a time. The header whose length makes the running total reach one buffer word is still taken, and the lanes after it wait for the next cycle. This keeps each group small enough that a later stage can accept or reject the whole group at once against free buffer space, without getting stuck on a group that only partly fits.

Reading stops completely while an almost-full signal from the end of the pipeline is high. A FIFO lane that holds no header ends the candidate list, so a group is always a contiguous run of lanes starting at lane 0. When reading is allowed and lane 0 holds a header, that header is always taken, so the reader keeps moving.

Top module: `hdr_group_reader`

## Requirements
- R1: While `rst` is high, `rd_cnt` is 0. After a clock edge with `rst` high, `grp_vld` is all zeros and every `grp_len` and `grp_meta` field is 0.
- R2: When `afull` is low and lane 0 of `fifo_vld` is set, lane 0 is taken and `rd_cnt` is at least 1, whatever the length of that header.
- R3: When `afull` is high, `rd_cnt` is 0, and after the next clock edge `grp_vld` is all zeros.
- R4: A lane i > 0 is taken only if lane i is available, lanes 0 to i-1 are all taken, and the sum of the lengths of lanes 0 to i-1 is below `WORD_BYTES`. With four 20-byte headers and a 32-byte word, exactly two are taken.
- R5: A lane whose `fifo_vld` bit is clear ends the candidate list. No lane above it is taken, even if that lane holds a header.
- R6: `rd_cnt` equals the number of lanes taken in that cycle, and after the next clock edge the number of set bits in `grp_vld` equals that count.
- R7: One clock edge after a lane is taken, its `grp_vld` bit is set and its `grp_len` and `grp_meta` fields hold that header's length and metadata. A lane that was not taken shows 0 in both fields. Lane k uses bits [k*LEN_W +: LEN_W] of the length buses and bits [k*META_W +: META_W] of the metadata buses.
- R8: A running total exactly equal to `WORD_BYTES` counts as reached: with lengths 16, 16, 16 and a 32-byte word, two lanes are taken. With lengths 16, 15, 1, 1, three lanes are taken. Zero-length headers never reach the limit, so four of them are all taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_vld | input | LANES | Per-lane header present at the FIFO output |
| fifo_len | input | LANES*LEN_W | Per-lane packet length in bytes |
| fifo_meta | input | LANES*META_W | Per-lane header metadata carried through |
| afull | input | 1 | Almost-full from the end of the pipeline; blocks all reads |
| rd_cnt | output | $clog2(LANES+1) | Number of headers taken this cycle, sent to the FIFO |
| grp_vld | output | LANES | Registered per-lane valid of the group |
| grp_len | output | LANES*LEN_W | Registered lengths of the group |
| grp_meta | output | LANES*META_W | Registered metadata of the group |

## Verification
The bench goes after where the running total meets the word size. A total landing exactly on `WORD_BYTES` must stop the group, and a reader that compared with less-or-equal would take one header too many. The bench also uses an oversized first header that must still be taken, because a reader that checked the lane's own length would stall for good. A gap in the available lanes with a header above it shows whether the prefix rule holds: a design that skipped the gap would read out of order. The afull cycles check both the read count and the following group, which catches a design that blocked only one of them.

// File: rtl/hgr_pkg.sv
package hgr_pkg;

    localparam int HGR_LANES_DEF = 4;
    localparam int HGR_LEN_W_DEF = 16;
    localparam int HGR_META_W_DEF = 8;
    localparam int HGR_WORD_DEF = 32;

    // Width of a count that can hold 0..n
    function automatic int hgr_cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Width of a sum of n values of w bits
    function automatic int hgr_sum_width(input int w, input int n);
        return w + $clog2(n + 1);
    endfunction

    typedef enum logic [0:0] {
        HGR_HOLD = 1'b0,
        HGR_READ = 1'b1
    } hgr_mode_e;

endpackage

// File: rtl/hgr_prefix_acc.sv
module hgr_prefix_acc #(
    parameter int LANES = 4,
    parameter int LEN_W = 16,
    parameter int SUM_W = 19
) (
    input  logic [LANES*LEN_W-1:0] lens,
    output logic [LANES*SUM_W-1:0] sums_before
);

    // Running total of all lanes below each lane
    assign sums_before[0 +: SUM_W] = '0;

    genvar i;
    generate
        for (i = 1; i < LANES; i++) begin : g_acc
            assign sums_before[i*SUM_W +: SUM_W] =
                sums_before[(i-1)*SUM_W +: SUM_W] +
                SUM_W'(lens[(i-1)*LEN_W +: LEN_W]);
        end
    endgenerate

endmodule

// File: rtl/hgr_select.sv
module hgr_select
    import hgr_pkg::*;
#(
    parameter int LANES = 4,
    parameter int SUM_W = 19,
    parameter int WORD_BYTES = 32,
    parameter int CNT_W = 3
) (
    input  logic                   rst,
    input  logic                   afull,
    input  logic [LANES-1:0]       avail,
    input  logic [LANES*SUM_W-1:0] sums_before,
    output logic [LANES-1:0]       take,
    output logic [CNT_W-1:0]       cnt
);

    localparam logic [SUM_W-1:0] WORD_LIM = SUM_W'(WORD_BYTES);

    hgr_mode_e mode;
    assign mode = (rst || afull) ? HGR_HOLD : HGR_READ;

    // Lane 0 ignores the word limit so progress is guaranteed
    assign take[0] = (mode == HGR_READ) && avail[0];

    genvar i;
    generate
        for (i = 1; i < LANES; i++) begin : g_take
            assign take[i] = take[i-1] && avail[i] &&
                             (sums_before[i*SUM_W +: SUM_W] < WORD_LIM);
        end
    endgenerate

    always_comb begin
        cnt = '0;
        for (int k = 0; k < LANES; k++) begin
            cnt = cnt + CNT_W'(take[k]);
        end
    end

    // R5: the taken set has no hole
    always_comb begin
        if (!rst) begin
            assert_take_prefix_R5: assert (((take + 1'b1) & take) == '0);
        end
    end

endmodule

// File: rtl/hdr_group_reader.sv
module hdr_group_reader
    import hgr_pkg::*;
#(
    parameter int LANES = HGR_LANES_DEF,
    parameter int LEN_W = HGR_LEN_W_DEF,
    parameter int META_W = HGR_META_W_DEF,
    parameter int WORD_BYTES = HGR_WORD_DEF,
    localparam int CNT_W = hgr_cnt_width(LANES),
    localparam int SUM_W = hgr_sum_width(LEN_W, LANES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        fifo_vld,
    input  logic [LANES*LEN_W-1:0]  fifo_len,
    input  logic [LANES*META_W-1:0] fifo_meta,
    input  logic                    afull,
    output logic [CNT_W-1:0]        rd_cnt,
    output logic [LANES-1:0]        grp_vld,
    output logic [LANES*LEN_W-1:0]  grp_len,
    output logic [LANES*META_W-1:0] grp_meta
);

    logic [LANES*SUM_W-1:0] sums_before;
    logic [LANES-1:0]       take;

    hgr_prefix_acc #(
        .LANES (LANES),
        .LEN_W (LEN_W),
        .SUM_W (SUM_W)
    ) u_acc (
        .lens        (fifo_len),
        .sums_before (sums_before)
    );

    hgr_select #(
        .LANES      (LANES),
        .SUM_W      (SUM_W),
        .WORD_BYTES (WORD_BYTES),
        .CNT_W      (CNT_W)
    ) u_sel (
        .rst         (rst),
        .afull       (afull),
        .avail       (fifo_vld),
        .sums_before (sums_before),
        .take        (take),
        .cnt         (rd_cnt)
    );

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst || !take[i]) begin
                    grp_len[i*LEN_W +: LEN_W]    <= '0;
                    grp_meta[i*META_W +: META_W] <= '0;
                end else begin
                    grp_len[i*LEN_W +: LEN_W]    <= fifo_len[i*LEN_W +: LEN_W];
                    grp_meta[i*META_W +: META_W] <= fifo_meta[i*META_W +: META_W];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_vld <= '0;
        end else begin
            grp_vld <= take;
        end
    end

    // R3: no reads under almost-full
    assert_afull_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        afull |-> (rd_cnt == '0));

    // R3: an almost-full cycle yields an empty group
    assert_afull_empty_group_R3: assert property (@(posedge clk) disable iff (rst)
        afull |=> (grp_vld == '0));

    // R2: the first available header always goes
    assert_progress_R2: assert property (@(posedge clk) disable iff (rst)
        (!afull && fifo_vld[0]) |-> (rd_cnt != '0));

    // R6: FIFO read count agrees with the registered group
    assert_count_matches_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(grp_vld) == int'($past(rd_cnt))));

    // R5: group lanes form a prefix
    assert_group_prefix_R5: assert property (@(posedge clk) disable iff (rst)
        ((grp_vld + 1'b1) & grp_vld) == '0);

endmodule

// File: tb/hdr_group_reader_bench.sv
`timescale 1ns/1ps
module hdr_group_reader_bench;

    localparam int LANES = 4;
    localparam int LEN_W = 16;
    localparam int META_W = 8;
    localparam int WORD = 32;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [LANES-1:0]        fifo_vld = '0;
    logic [LANES*LEN_W-1:0]  fifo_len = '0;
    logic [LANES*META_W-1:0] fifo_meta = '0;
    logic                    afull = 1'b0;
    logic [2:0]              rd_cnt;
    logic [LANES-1:0]        grp_vld;
    logic [LANES*LEN_W-1:0]  grp_len;
    logic [LANES*META_W-1:0] grp_meta;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    hdr_group_reader #(
        .LANES (LANES), .LEN_W (LEN_W), .META_W (META_W), .WORD_BYTES (WORD)
    ) u_hdr_group_reader (
        .clk (clk), .rst (rst), .fifo_vld (fifo_vld), .fifo_len (fifo_len),
        .fifo_meta (fifo_meta), .afull (afull), .rd_cnt (rd_cnt),
        .grp_vld (grp_vld), .grp_len (grp_len), .grp_meta (grp_meta)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected count from the rules: prefix of available lanes, word limit
    function automatic int model_cnt(input logic [3:0] v, input int l0, input int l1,
                                     input int l2, input int l3, input logic af);
        int lens[4];
        int sum = 0;
        int n = 0;
        lens = '{l0, l1, l2, l3};
        if (af) return 0;
        for (int k = 0; k < LANES; k++) begin
            if (!v[k]) break;
            if (k > 0 && sum >= WORD) break;
            sum += lens[k];
            n++;
        end
        return n;
    endfunction

    // Drive one cycle, check rd_cnt, then the registered group
    task automatic run(input string req, input logic [3:0] v, input int l0, input int l1,
                       input int l2, input int l3, input logic af, input int exp_cnt);
        int lens[4];
        int m;
        lens = '{l0, l1, l2, l3};
        @(negedge clk);
        fifo_vld = v;
        afull = af;
        for (int k = 0; k < LANES; k++) begin
            fifo_len[k*LEN_W +: LEN_W] = LEN_W'(lens[k]);
            fifo_meta[k*META_W +: META_W] = META_W'(8'hA0 + k);
        end
        #1;
        m = model_cnt(v, l0, l1, l2, l3, af);
        check({req, " model"}, m, exp_cnt);
        check({req, " rd_cnt"}, int'(rd_cnt), exp_cnt);
        @(posedge clk);
        #1;
        check({req, " grp_vld R6"}, int'(grp_vld), (1 << exp_cnt) - 1);
        for (int k = 0; k < LANES; k++) begin
            check({req, " grp_len R7"}, int'(grp_len[k*LEN_W +: LEN_W]),
                  (k < exp_cnt) ? lens[k] : 0);
            check({req, " grp_meta R7"}, int'(grp_meta[k*META_W +: META_W]),
                  (k < exp_cnt) ? (8'hA0 + k) : 0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        fifo_vld = 4'hF;
        fifo_len = {4{16'd4}};
        #1;
        check("R1 rd_cnt in reset", int'(rd_cnt), 0);
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1 grp_vld", int'(grp_vld), 0);
        check("R1 grp_len", int'(grp_len), 0);
        check("R1 grp_meta", int'(grp_meta), 0);
        check("R1 rd_cnt held", int'(rd_cnt), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_word_limit();
        run("R4 four 20s", 4'hF, 20, 20, 20, 20, 1'b0, 2);
        run("R4 small", 4'hF, 4, 4, 4, 4, 1'b0, 4);
        run("R4 mid", 4'hF, 10, 10, 10, 10, 1'b0, 4);
        run("R4 three", 4'hF, 8, 8, 20, 5, 1'b0, 3);
    endtask

    task automatic t_exact();
        run("R8 exact 16+16", 4'hF, 16, 16, 16, 16, 1'b0, 2);
        run("R8 16,15,1", 4'hF, 16, 15, 1, 1, 1'b0, 3);
        run("R8 zero lens", 4'hF, 0, 0, 0, 0, 1'b0, 4);
        run("R8 first word", 4'hF, 32, 1, 1, 1, 1'b0, 1);
    endtask

    task automatic t_progress();
        run("R2 oversized first", 4'hF, 100, 1, 1, 1, 1'b0, 1);
        run("R2 single lane", 4'h1, 5, 5, 5, 5, 1'b0, 1);
    endtask

    task automatic t_afull();
        run("R3 afull", 4'hF, 4, 4, 4, 4, 1'b1, 0);
        run("R3 after afull", 4'hF, 4, 4, 4, 4, 1'b0, 4);
    endtask

    task automatic t_gaps();
        run("R5 hole at 1", 4'b1101, 2, 2, 2, 2, 1'b0, 1);
        run("R5 hole at 2", 4'b1011, 2, 2, 2, 2, 1'b0, 2);
        run("R5 lane0 empty", 4'b1110, 2, 2, 2, 2, 1'b0, 0);
        run("R5 none", 4'b0000, 2, 2, 2, 2, 1'b0, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_word_limit();
                t_exact();
                t_progress();
                t_afull();
                t_gaps();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule